// File: doc/BRIEF.md
# Memory-Mapped Operator Word File

This block is the whole data memory of a processor whose only instruction is a move from one word to another. It holds 256 words of 16 bits, addressed by an 8-bit word address. All arithmetic and logic lives in a handful of low addresses. Reading one of these addresses returns a value computed from other stored words rather than the word itself. A program computes by moving operands into these words and then moving the result word somewhere else.

The block has one synchronous write port and one combinational read port. Writing address 0x00 loads the 8-bit program counter, and that counter is shown on a dedicated output. Word 0x0B is ordinary storage, and its value is also driven to a display output. Two shift words keep only 15 bits each.

Reset clears every word. After reset, contents are loaded through the write port.

Top module: `xfer_opfile`

## Requirements
- R1: While rst_ni is low, every stored word clears to zero. After reset, pc_o and disp_o read 0 and plain words read 0. Address 0x07 reads 0xFFFF and address 0x08 reads 0xFFFF.
- R2: Addresses 0x01, 0x02, 0x03, 0x05, 0x0B and 0x0C through 0xFF read back the full 16-bit value last written to them.
- R3: Reading address 0x00 returns the sum of word 0x01 and word 0x02, modulo 2^16.
- R4: A write to address 0x00 loads the low 8 bits of the write data into the program counter, shown on pc_o. It does not change what address 0x00 reads.
- R5: Reading address 0x04 returns word 0x04 when word 0x01 + word 0x02 is at least 0x10000. Otherwise it returns word 0x03.
- R6: Reading address 0x06 returns word 0x05 when word 0x01 equals word 0x02. Otherwise it returns word 0x06.
- R7: Reading address 0x07 returns the bitwise inverse of word 0x07.
- R8: Reading address 0x08 returns the bitwise NOR of word 0x07 and word 0x08.
- R9: Word 0x09 stores only bits 14:0 of the write data. Reading it returns the stored value, zero-extended to 16 bits and shifted left by one with a 0 entering bit 0.
- R10: Word 0x0A stores only bits 14:0 of the write data. Reading it returns the stored value shifted right by one. Bit 14 is both kept in place and copied into bit 13. Bit 15 of the result is 0, and stored bit 0 is lost.
- R11: disp_o always equals word 0x0B.
- R12: A write takes effect at the rising clock edge. A read of the same address in the write cycle returns the old value. Words that are not written keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all words |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 8 | Write word address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 8 | Read word address |
| rd_data_o | output | 16 | Read data, stored or computed (combinational) |
| pc_o | output | 8 | Program counter (word 0x00) |
| disp_o | output | 16 | Display word (word 0x0B) |

## Verification
A read result depends on the current read address and on the stored words, so it is due in the same cycle the address is applied. The bench sets the address at the falling edge and compares the result 2 ns later, before the next rising edge. A write, and the pc_o or disp_o value it produces, is due only after the next rising edge. Checks that depend on a write are queued one falling edge later than that rising edge. The same-cycle read test applies write and read together and compares before the edge, so it must see the old value.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 8;
  localparam int PC_W    = 8;
  localparam int SHIFT_W = 15;
  localparam int NUM_TAPS = 12;

  localparam logic [ADDR_W-1:0] A_SUM  = 8'h00;
  localparam logic [ADDR_W-1:0] A_OPA  = 8'h01;
  localparam logic [ADDR_W-1:0] A_OPB  = 8'h02;
  localparam logic [ADDR_W-1:0] A_CARA = 8'h03;
  localparam logic [ADDR_W-1:0] A_CARB = 8'h04;
  localparam logic [ADDR_W-1:0] A_EQA  = 8'h05;
  localparam logic [ADDR_W-1:0] A_EQB  = 8'h06;
  localparam logic [ADDR_W-1:0] A_NORA = 8'h07;
  localparam logic [ADDR_W-1:0] A_NORB = 8'h08;
  localparam logic [ADDR_W-1:0] A_SHL  = 8'h09;
  localparam logic [ADDR_W-1:0] A_SAR  = 8'h0A;
  localparam logic [ADDR_W-1:0] A_DISP = 8'h0B;

  // storage width per word: narrow words drop upper bits on write
  function automatic logic [DATA_W-1:0] word_mask(input logic [ADDR_W-1:0] a);
    case (a)
      A_SUM:        word_mask = DATA_W'((1 << PC_W) - 1);
      A_SHL, A_SAR: word_mask = DATA_W'((1 << SHIFT_W) - 1);
      default:      word_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/opf_store.sv
module opf_store
  import opf_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int NTAPS = NUM_TAPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_raw_o,
  output logic [DW-1:0] tap_o [NTAPS]
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i & word_mask(wr_addr_i);
    end
  end

  assign rd_raw_o = mem_q[rd_addr_i];

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign tap_o[g] = mem_q[g];
  end

  // R9: shift word keeps no bit 15
  a_r9_narrow_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SHL) |=> (tap_o[A_SHL][DW-1] == 1'b0));
endmodule

// File: rtl/opf_ops.sv
module opf_ops
  import opf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SHIFT_W
) (
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] cara_i,
  input  logic [DW-1:0] carb_i,
  input  logic [DW-1:0] eqa_i,
  input  logic [DW-1:0] eqb_i,
  input  logic [DW-1:0] nora_i,
  input  logic [DW-1:0] norb_i,
  input  logic [DW-1:0] shl_i,
  input  logic [DW-1:0] sar_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] carry_sel_o,
  output logic [DW-1:0] eq_sel_o,
  output logic [DW-1:0] inv_o,
  output logic [DW-1:0] nor_o,
  output logic [DW-1:0] shl_o,
  output logic [DW-1:0] sar_o
);
  logic [DW:0] sum_full;

  assign sum_full    = {1'b0, opa_i} + {1'b0, opb_i};
  assign sum_o       = sum_full[DW-1:0];
  assign carry_sel_o = sum_full[DW] ? carb_i : cara_i;
  assign eq_sel_o    = (opa_i == opb_i) ? eqa_i : eqb_i;
  assign inv_o       = ~nora_i;
  assign nor_o       = ~(nora_i | norb_i);
  assign shl_o       = {shl_i[DW-2:0], 1'b0};
  // sign taken from top stored bit of the narrow word
  assign sar_o       = {{(DW-SW){1'b0}}, sar_i[SW-1], sar_i[SW-1:1]};
endmodule

// File: rtl/xfer_opfile.sv
module xfer_opfile
  import opf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] disp_o
);
  logic [DATA_W-1:0] rd_raw;
  logic [DATA_W-1:0] tap [NUM_TAPS];
  logic [DATA_W-1:0] sum, carry_sel, eq_sel, inv, nor_v, shl, sar;

  opf_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_raw_o  (rd_raw),
    .tap_o     (tap)
  );

  opf_ops u_ops (
    .opa_i       (tap[A_OPA]),
    .opb_i       (tap[A_OPB]),
    .cara_i      (tap[A_CARA]),
    .carb_i      (tap[A_CARB]),
    .eqa_i       (tap[A_EQA]),
    .eqb_i       (tap[A_EQB]),
    .nora_i      (tap[A_NORA]),
    .norb_i      (tap[A_NORB]),
    .shl_i       (tap[A_SHL]),
    .sar_i       (tap[A_SAR]),
    .sum_o       (sum),
    .carry_sel_o (carry_sel),
    .eq_sel_o    (eq_sel),
    .inv_o       (inv),
    .nor_o       (nor_v),
    .shl_o       (shl),
    .sar_o       (sar)
  );

  always_comb begin
    case (rd_addr_i)
      A_SUM:   rd_data_o = sum;
      A_CARB:  rd_data_o = carry_sel;
      A_EQB:   rd_data_o = eq_sel;
      A_NORA:  rd_data_o = inv;
      A_NORB:  rd_data_o = nor_v;
      A_SHL:   rd_data_o = shl;
      A_SAR:   rd_data_o = sar;
      default: rd_data_o = rd_raw;
    endcase
  end

  assign pc_o   = tap[A_SUM][PC_W-1:0];
  assign disp_o = tap[A_DISP];

  // R4
  a_r4_pc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SUM) |=> (pc_o == $past(wr_data_i[PC_W-1:0])));
  // R11
  a_r11_disp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_DISP) |=> (disp_o == $past(wr_data_i)));
  // R12
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pc_o) && $stable(disp_o)));
  // R1
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pc_o == '0 && disp_o == '0));
endmodule

// File: tb/xfer_opfile_tb_top.sv
module xfer_opfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  pc;
  logic [15:0] disp;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int          kind;  // 0 read, 1 pc, 2 disp
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q [$];

  always #2.5 clk = ~clk;

  xfer_opfile dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .pc_o      (pc),
    .disp_o    (disp)
  );

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_addr = a;
    sb_q.push_back('{0, e, t});
  endtask

  task automatic chk_pc(input logic [7:0] e, input string t);
    @(negedge clk);
    sb_q.push_back('{1, {8'h00, e}, t});
  endtask

  task automatic chk_disp(input logic [15:0] e, input string t);
    @(negedge clk);
    sb_q.push_back('{2, e, t});
  endtask

  // write and read the same address in one cycle: old value due
  task automatic wr_rd(input logic [7:0] a, input logic [15:0] d,
                       input logic [15:0] old, input string t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = a;
    sb_q.push_back('{0, old, t});
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // monitor: compares before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = rd_data;
          1:       act = {8'h00, pc};
          default: act = disp;
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(8'h00, 16'h0000, "R1 sum after reset");
    rd(8'h07, 16'hFFFF, "R1 inv after reset");
    rd(8'h08, 16'hFFFF, "R1 nor after reset");
    rd(8'h55, 16'h0000, "R1 plain after reset");
    chk_pc(8'h00, "R1 pc after reset");
    chk_disp(16'h0000, "R1 disp after reset");

    wr(8'h01, 16'h1234);
    wr(8'h02, 16'h4321);
    rd(8'h01, 16'h1234, "R2 opa readback");
    rd(8'h00, 16'h5555, "R3 sum");

    wr(8'h03, 16'hAAAA);
    wr(8'h04, 16'hBBBB);
    rd(8'h04, 16'hAAAA, "R5 no carry");
    wr(8'h01, 16'hFFFF);
    wr(8'h02, 16'h0001);
    rd(8'h00, 16'h0000, "R3 sum wraps");
    rd(8'h04, 16'hBBBB, "R5 carry at 0x10000");
    wr(8'h02, 16'h0000);
    rd(8'h04, 16'hAAAA, "R5 sum 0xFFFF no carry");

    wr(8'h05, 16'h1111);
    wr(8'h06, 16'h2222);
    rd(8'h06, 16'h2222, "R6 unequal");
    wr(8'h02, 16'hFFFF);
    rd(8'h06, 16'h1111, "R6 equal");
    rd(8'h05, 16'h1111, "R2 eqa readback");
    rd(8'h03, 16'hAAAA, "R2 cara readback");

    wr(8'h07, 16'h0F0F);
    rd(8'h07, 16'hF0F0, "R7 inverse");
    wr(8'h08, 16'h00FF);
    rd(8'h08, 16'hF000, "R8 nor");

    wr(8'h09, 16'hC001);
    rd(8'h09, 16'h8002, "R9 bit15 dropped then shl");
    wr(8'h09, 16'h4000);
    rd(8'h09, 16'h8000, "R9 top bit to bit15");
    wr(8'h09, 16'h8000);
    rd(8'h09, 16'h0000, "R9 only bit15 written");

    wr(8'h0A, 16'h4002);
    rd(8'h0A, 16'h6001, "R10 sign bit14 kept");
    wr(8'h0A, 16'h0006);
    rd(8'h0A, 16'h0003, "R10 positive");
    wr(8'h0A, 16'hFFFF);
    rd(8'h0A, 16'h7FFF, "R10 all ones narrow");

    wr(8'h00, 16'hABCD);
    chk_pc(8'hCD, "R4 pc load");
    rd(8'h00, 16'hFFFE, "R4 sum read unaffected");

    wr(8'h0B, 16'hBEEF);
    chk_disp(16'hBEEF, "R11 disp follows word");
    rd(8'h0B, 16'hBEEF, "R2 disp word readback");

    wr(8'hFF, 16'h5A5A);
    rd(8'hFF, 16'h5A5A, "R2 top word");
    wr(8'h0C, 16'h0001);
    rd(8'h0C, 16'h0001, "R2 first plain word");
    rd(8'hFE, 16'h0000, "R2 unwritten word");

    wr_rd(8'h20, 16'h7777, 16'h0000, "R12 same-cycle read old");
    rd(8'h20, 16'h7777, "R12 read after edge");
    chk_disp(16'hBEEF, "R12 disp held");
    chk_pc(8'hCD, "R12 pc held");
    rd(8'hFF, 16'h5A5A, "R12 other word held");

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule